// File: doc/BRIEF.md
# Data Effective Address Generator

This unit turns an operand request from a 16-bit DSP-style core into a data-space effective address. A request carries a 3-bit addressing-mode code, a pointer register select, an offset register select, a 10-bit literal, a 13-bit direct field, a byte/word flag and a modify direction. The unit holds a bank of sixteen 16-bit working registers. It reads the selected pointer from that bank, forms the address, and for the two modify modes produces the updated pointer for writeback. The core writes ALU results into the same bank through a load port.

All results are registered and appear one cycle after the request. A pointer update appears as a writeback strobe with the register index and the new value. It lands in the bank at the following edge and is forwarded to a read of the same register in the cycle in between. Register direct operands use no memory, so the unit flags them with a no-memory strobe instead of an address. Word accesses that resolve to an odd address raise an alignment error.

Top module: `data_ea_gen`

## Requirements
- R1: Mode code 0 (file direct) gives ea = the 13-bit direct field zero-extended to 16 bits, and reg_data = the current value of register 0.
- R2: Mode code 1 (register direct) gives no_mem = 1, ea_valid = 0, ea = 0, reg_data = the selected register Wn, and no writeback.
- R3: Mode code 2 (indirect) gives ea = Wn, with no writeback.
- R4: Mode code 3 (post-modify) gives ea = the old Wn and a writeback of Wn plus the step to index Wn.
- R5: Mode code 4 (pre-modify) gives ea = Wn plus the step, and the same value is written back to Wn.
- R6: The step is 1 when is_byte = 1 and 2 when is_byte = 0. It is negated when step_down = 1.
- R7: Mode code 5 (register offset) gives ea = Wn + Wb, with no writeback.
- R8: Mode code 6 (literal offset) gives ea = Wn + the sign-extended 10-bit literal, with no writeback.
- R9: addr_err = 1 exactly when ea_valid = 1, is_byte = 0 and ea bit 0 = 1.
- R10: All arithmetic wraps modulo 2^16 and raises no flag of its own.
- R11: A request in the cycle right after a writeback sees the written value for that register.
- R12: All outputs appear one cycle after the request. A cycle with no request, or with mode code 7, clears every output to zero on the next cycle.
- R13: A load writes the register so that it is visible the next cycle. When a load and a pending writeback target the same register, the load wins.
- R14: Synchronous reset clears all registers and all outputs to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Address request this cycle |
| mode | input | 3 | Addressing-mode code (0..7) |
| wn_sel | input | 4 | Pointer register select |
| wb_sel | input | 4 | Offset register select |
| lit_ofs | input | 10 | Signed literal offset |
| file_addr | input | 13 | Direct file-address field |
| is_byte | input | 1 | 1 = byte access, 0 = word access |
| step_down | input | 1 | 1 = modify step is negative |
| ld_en | input | 1 | Core register load strobe |
| ld_idx | input | 4 | Load register index |
| ld_data | input | 16 | Load value |
| ea_valid | output | 1 | Effective address valid |
| ea | output | 16 | Effective address |
| no_mem | output | 1 | Register direct operand, no memory access |
| addr_err | output | 1 | Odd word address |
| reg_data | output | 16 | Register operand (Wn in register direct, register 0 in file direct) |
| wb_en | output | 1 | Pointer writeback strobe |
| wb_idx | output | 4 | Writeback register index |
| wb_data | output | 16 | Writeback value |

## Verification
The hardest case to reach from the ports is the cycle where a pointer update is still in flight. Its writeback is pending but not yet in the bank, and a new request or a core load targets the same register. The vector table issues modify requests on the same pointer back to back, so the second request can only see the right value through forwarding. A directed sequence then places a load to a register in the very cycle its pointer writeback is pending, and reads it back through register direct mode. Wraparound is reached by modifying pointers preloaded to 0xFFFF and 0x8000 and by negative literals.

// File: rtl/eagen_pkg.sv
package eagen_pkg;
    localparam int DATA_W = 16;
    localparam int NUM_REGS = 16;
    localparam int IDX_W = $clog2(NUM_REGS);
    localparam int FADDR_W = 13;
    localparam int LIT_W = 10;
    localparam int MODE_W = 3;

    typedef logic [DATA_W-1:0] word_t;
    typedef logic [IDX_W-1:0] ridx_t;

    typedef enum logic [MODE_W-1:0] {
        AM_FILE = 3'd0,
        AM_REG  = 3'd1,
        AM_IND  = 3'd2,
        AM_POST = 3'd3,
        AM_PRE  = 3'd4,
        AM_ROFS = 3'd5,
        AM_LOFS = 3'd6,
        AM_NONE = 3'd7
    } amode_e;

    typedef struct packed {
        logic  ea_valid;
        word_t ea;
        logic  no_mem;
        logic  addr_err;
        word_t reg_data;
        logic  wb_en;
        ridx_t wb_idx;
        word_t wb_data;
    } ea_result_t;

    function automatic word_t step_amount(input logic byte_acc, input logic down);
        word_t mag;
        mag = byte_acc ? word_t'(1) : word_t'(2);
        return down ? (~mag + word_t'(1)) : mag;
    endfunction

    function automatic word_t sext_lit(input logic [LIT_W-1:0] lit);
        return {{(DATA_W-LIT_W){lit[LIT_W-1]}}, lit};
    endfunction
endpackage

// File: rtl/eagen_regbank.sv
module eagen_regbank
    import eagen_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  ld_en,
    input  ridx_t ld_idx,
    input  word_t ld_data,
    input  logic  pend_en,
    input  ridx_t pend_idx,
    input  word_t pend_data,
    input  ridx_t rd_a_idx,
    input  ridx_t rd_b_idx,
    output word_t rd_a,
    output word_t rd_b,
    output word_t rd_zero
);
    word_t bank [NUM_REGS];

    for (genvar i = 0; i < NUM_REGS; i++) begin : g_reg
        always_ff @(posedge clk) begin
            if (rst) begin
                bank[i] <= '0;
            end else if (ld_en && ld_idx == ridx_t'(i)) begin
                bank[i] <= ld_data;
            end else if (pend_en && pend_idx == ridx_t'(i)) begin
                bank[i] <= pend_data;
            end
        end
    end

    function automatic word_t fwd_read(input ridx_t idx, input word_t raw);
        return (pend_en && pend_idx == idx) ? pend_data : raw;
    endfunction

    assign rd_a    = fwd_read(rd_a_idx, bank[rd_a_idx]);
    assign rd_b    = fwd_read(rd_b_idx, bank[rd_b_idx]);
    assign rd_zero = fwd_read(ridx_t'(0), bank[0]);
endmodule

// File: rtl/eagen_calc.sv
module eagen_calc
    import eagen_pkg::*;
(
    input  amode_e               mode,
    input  ridx_t                wn_sel,
    input  word_t                wn_val,
    input  word_t                wb_val,
    input  word_t                w0_val,
    input  logic [LIT_W-1:0]     lit_ofs,
    input  logic [FADDR_W-1:0]   file_addr,
    input  logic                 is_byte,
    input  logic                 step_down,
    output ea_result_t           res
);
    word_t step;
    word_t modded;

    assign step   = step_amount(is_byte, step_down);
    assign modded = wn_val + step;

    always_comb begin
        res = '0;
        unique case (mode)
            AM_FILE: begin
                res.ea_valid = 1'b1;
                res.ea       = {{(DATA_W-FADDR_W){1'b0}}, file_addr};
                res.reg_data = w0_val;
            end
            AM_REG: begin
                res.no_mem   = 1'b1;
                res.reg_data = wn_val;
            end
            AM_IND: begin
                res.ea_valid = 1'b1;
                res.ea       = wn_val;
            end
            AM_POST: begin
                res.ea_valid = 1'b1;
                res.ea       = wn_val;
                res.wb_en    = 1'b1;
                res.wb_idx   = wn_sel;
                res.wb_data  = modded;
            end
            AM_PRE: begin
                res.ea_valid = 1'b1;
                res.ea       = modded;
                res.wb_en    = 1'b1;
                res.wb_idx   = wn_sel;
                res.wb_data  = modded;
            end
            AM_ROFS: begin
                res.ea_valid = 1'b1;
                res.ea       = wn_val + wb_val;
            end
            AM_LOFS: begin
                res.ea_valid = 1'b1;
                res.ea       = wn_val + sext_lit(lit_ofs);
            end
            default: res = '0;
        endcase
        res.addr_err = res.ea_valid && !is_byte && res.ea[0];
    end
endmodule

// File: rtl/data_ea_gen.sv
module data_ea_gen
    import eagen_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        req_valid,
    input  logic [2:0]  mode,
    input  logic [3:0]  wn_sel,
    input  logic [3:0]  wb_sel,
    input  logic [9:0]  lit_ofs,
    input  logic [12:0] file_addr,
    input  logic        is_byte,
    input  logic        step_down,
    input  logic        ld_en,
    input  logic [3:0]  ld_idx,
    input  logic [15:0] ld_data,
    output logic        ea_valid,
    output logic [15:0] ea,
    output logic        no_mem,
    output logic        addr_err,
    output logic [15:0] reg_data,
    output logic        wb_en,
    output logic [3:0]  wb_idx,
    output logic [15:0] wb_data
);
    ea_result_t res_d;
    ea_result_t res_q;
    word_t      wn_val;
    word_t      wb_val;
    word_t      w0_val;

    eagen_regbank u_bank (
        .clk       (clk),
        .rst       (rst),
        .ld_en     (ld_en),
        .ld_idx    (ld_idx),
        .ld_data   (ld_data),
        .pend_en   (res_q.wb_en),
        .pend_idx  (res_q.wb_idx),
        .pend_data (res_q.wb_data),
        .rd_a_idx  (wn_sel),
        .rd_b_idx  (wb_sel),
        .rd_a      (wn_val),
        .rd_b      (wb_val),
        .rd_zero   (w0_val)
    );

    eagen_calc u_calc (
        .mode      (amode_e'(mode)),
        .wn_sel    (wn_sel),
        .wn_val    (wn_val),
        .wb_val    (wb_val),
        .w0_val    (w0_val),
        .lit_ofs   (lit_ofs),
        .file_addr (file_addr),
        .is_byte   (is_byte),
        .step_down (step_down),
        .res       (res_d)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            res_q <= '0;
        end else begin
            res_q <= req_valid ? res_d : '0;
        end
    end

    assign ea_valid = res_q.ea_valid;
    assign ea       = res_q.ea;
    assign no_mem   = res_q.no_mem;
    assign addr_err = res_q.addr_err;
    assign reg_data = res_q.reg_data;
    assign wb_en    = res_q.wb_en;
    assign wb_idx   = res_q.wb_idx;
    assign wb_data  = res_q.wb_data;
endmodule

// File: rtl/data_ea_gen_chk.sv
module data_ea_gen_chk (
    input logic        clk,
    input logic        rst,
    input logic        req_valid,
    input logic [2:0]  mode,
    input logic [3:0]  wn_sel,
    input logic [12:0] file_addr,
    input logic        is_byte,
    input logic        ea_valid,
    input logic [15:0] ea,
    input logic        no_mem,
    input logic        addr_err,
    input logic        wb_en,
    input logic [3:0]  wb_idx,
    input logic [15:0] wb_data
);
    a_r1_file_zero_ext: assert property (@(posedge clk) disable iff (rst)
        (req_valid && mode == 3'd0) |=> (ea_valid && ea == {3'b000, $past(file_addr)}));

    a_r2_reg_no_mem: assert property (@(posedge clk) disable iff (rst)
        (req_valid && mode == 3'd1) |=> (no_mem && !ea_valid && !wb_en));

    a_r4_post_wb_index: assert property (@(posedge clk) disable iff (rst)
        (req_valid && mode == 3'd3) |=> (wb_en && wb_idx == $past(wn_sel)));

    a_r5_pre_ea_matches_wb: assert property (@(posedge clk) disable iff (rst)
        (req_valid && mode == 3'd4) |=> (wb_en && ea_valid && ea == wb_data));

    a_r7_r8_offset_no_wb: assert property (@(posedge clk) disable iff (rst)
        (req_valid && (mode == 3'd2 || mode == 3'd5 || mode == 3'd6)) |=> (ea_valid && !wb_en));

    a_r9_addr_err_cause: assert property (@(posedge clk) disable iff (rst)
        addr_err |-> (ea_valid && ea[0] && !$past(is_byte)));

    a_r9_byte_never_err: assert property (@(posedge clk) disable iff (rst)
        (req_valid && is_byte) |=> !addr_err);

    a_r12_idle_quiet: assert property (@(posedge clk) disable iff (rst)
        (!req_valid || mode == 3'd7) |=> (!ea_valid && !no_mem && !wb_en && !addr_err));

    a_r2_flags_exclusive: assert property (@(posedge clk) disable iff (rst)
        $onehot0({ea_valid, no_mem}));
endmodule

bind data_ea_gen data_ea_gen_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .req_valid (req_valid),
    .mode      (mode),
    .wn_sel    (wn_sel),
    .file_addr (file_addr),
    .is_byte   (is_byte),
    .ea_valid  (ea_valid),
    .ea        (ea),
    .no_mem    (no_mem),
    .addr_err  (addr_err),
    .wb_en     (wb_en),
    .wb_idx    (wb_idx),
    .wb_data   (wb_data)
);

// File: tb/data_ea_gen_tb.sv
module data_ea_gen_tb;
    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG_CYCLES = 200000;

    logic        clk = 1'b0;
    logic        rst;
    logic        req_valid;
    logic [2:0]  mode;
    logic [3:0]  wn_sel;
    logic [3:0]  wb_sel;
    logic [9:0]  lit_ofs;
    logic [12:0] file_addr;
    logic        is_byte;
    logic        step_down;
    logic        ld_en;
    logic [3:0]  ld_idx;
    logic [15:0] ld_data;
    logic        ea_valid;
    logic [15:0] ea;
    logic        no_mem;
    logic        addr_err;
    logic [15:0] reg_data;
    logic        wb_en;
    logic [3:0]  wb_idx;
    logic [15:0] wb_data;

    int checks = 0;
    int errors = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    data_ea_gen u_dut (
        .clk(clk), .rst(rst), .req_valid(req_valid), .mode(mode),
        .wn_sel(wn_sel), .wb_sel(wb_sel), .lit_ofs(lit_ofs),
        .file_addr(file_addr), .is_byte(is_byte), .step_down(step_down),
        .ld_en(ld_en), .ld_idx(ld_idx), .ld_data(ld_data),
        .ea_valid(ea_valid), .ea(ea), .no_mem(no_mem), .addr_err(addr_err),
        .reg_data(reg_data), .wb_en(wb_en), .wb_idx(wb_idx), .wb_data(wb_data)
    );

    typedef struct packed {
        logic [2:0]  md;
        logic [3:0]  wn;
        logic [3:0]  wb;
        logic [9:0]  lit;
        logic [12:0] fa;
        logic        byt;
        logic        dn;
        logic        x_valid;
        logic [15:0] x_ea;
        logic        x_nomem;
        logic        x_err;
        logic        x_wben;
        logic [15:0] x_wbdata;
        logic [15:0] x_reg;
    } vec_t;

    localparam int NVEC = 17;
    // Preload: W0=1000 W1=2001 W2=0010 W3=FFFF W4=8000 W5=0003
    localparam vec_t TBL [NVEC] = '{
        '{3'd0, 4'd0, 4'd0, 10'h000, 13'h1ABC, 1'b0, 1'b0, 1'b1, 16'h1ABC, 1'b0, 1'b0, 1'b0, 16'h0000, 16'h1000}, // R1
        '{3'd0, 4'd0, 4'd0, 10'h000, 13'h1FFF, 1'b1, 1'b0, 1'b1, 16'h1FFF, 1'b0, 1'b0, 1'b0, 16'h0000, 16'h1000}, // R1 byte
        '{3'd1, 4'd3, 4'd0, 10'h000, 13'h0000, 1'b0, 1'b0, 1'b0, 16'h0000, 1'b1, 1'b0, 1'b0, 16'h0000, 16'hFFFF}, // R2
        '{3'd2, 4'd1, 4'd0, 10'h000, 13'h0000, 1'b0, 1'b0, 1'b1, 16'h2001, 1'b0, 1'b1, 1'b0, 16'h0000, 16'h0000}, // R3 R9
        '{3'd2, 4'd1, 4'd0, 10'h000, 13'h0000, 1'b1, 1'b0, 1'b1, 16'h2001, 1'b0, 1'b0, 1'b0, 16'h0000, 16'h0000}, // R9 byte
        '{3'd3, 4'd2, 4'd0, 10'h000, 13'h0000, 1'b0, 1'b0, 1'b1, 16'h0010, 1'b0, 1'b0, 1'b1, 16'h0012, 16'h0000}, // R4 R6
        '{3'd3, 4'd2, 4'd0, 10'h000, 13'h0000, 1'b0, 1'b1, 1'b1, 16'h0012, 1'b0, 1'b0, 1'b1, 16'h0010, 16'h0000}, // R11
        '{3'd4, 4'd2, 4'd0, 10'h000, 13'h0000, 1'b1, 1'b0, 1'b1, 16'h0011, 1'b0, 1'b0, 1'b1, 16'h0011, 16'h0000}, // R5 R6
        '{3'd4, 4'd3, 4'd0, 10'h000, 13'h0000, 1'b0, 1'b0, 1'b1, 16'h0001, 1'b0, 1'b1, 1'b1, 16'h0001, 16'h0000}, // R10
        '{3'd4, 4'd4, 4'd0, 10'h000, 13'h0000, 1'b1, 1'b1, 1'b1, 16'h7FFF, 1'b0, 1'b0, 1'b1, 16'h7FFF, 16'h0000}, // R6 down
        '{3'd5, 4'd0, 4'd5, 10'h000, 13'h0000, 1'b0, 1'b0, 1'b1, 16'h1003, 1'b0, 1'b1, 1'b0, 16'h0000, 16'h0000}, // R7
        '{3'd5, 4'd4, 4'd3, 10'h000, 13'h0000, 1'b0, 1'b0, 1'b1, 16'h8000, 1'b0, 1'b0, 1'b0, 16'h0000, 16'h0000}, // R7 R11
        '{3'd6, 4'd0, 4'd0, 10'h3FF, 13'h0000, 1'b1, 1'b0, 1'b1, 16'h0FFF, 1'b0, 1'b0, 1'b0, 16'h0000, 16'h0000}, // R8 neg
        '{3'd6, 4'd0, 4'd0, 10'h1FF, 13'h0000, 1'b0, 1'b0, 1'b1, 16'h11FF, 1'b0, 1'b1, 1'b0, 16'h0000, 16'h0000}, // R8 pos
        '{3'd6, 4'd3, 4'd0, 10'h200, 13'h0000, 1'b0, 1'b0, 1'b1, 16'hFE01, 1'b0, 1'b1, 1'b0, 16'h0000, 16'h0000}, // R8 R10
        '{3'd7, 4'd3, 4'd0, 10'h000, 13'h0000, 1'b0, 1'b0, 1'b0, 16'h0000, 1'b0, 1'b0, 1'b0, 16'h0000, 16'h0000}, // R12
        '{3'd3, 4'd3, 4'd0, 10'h000, 13'h0000, 1'b0, 1'b1, 1'b1, 16'h0001, 1'b0, 1'b1, 1'b1, 16'hFFFF, 16'h0000}  // R4 R10
    };

    task automatic check16(input string req, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic idle_inputs();
        req_valid = 1'b0; mode = 3'd0; wn_sel = '0; wb_sel = '0; lit_ofs = '0;
        file_addr = '0; is_byte = 1'b0; step_down = 1'b0;
        ld_en = 1'b0; ld_idx = '0; ld_data = '0;
    endtask

    task automatic load_reg(input logic [3:0] idx, input logic [15:0] val);
        ld_en = 1'b1; ld_idx = idx; ld_data = val;
        @(negedge clk);
        ld_en = 1'b0;
    endtask

    task automatic drive_req(input logic [2:0] md, input logic [3:0] wn, input logic byt, input logic dn);
        req_valid = 1'b1; mode = md; wn_sel = wn; is_byte = byt; step_down = dn;
    endtask

    initial begin
        #(CLK_PERIOD * WATCHDOG_CYCLES);
        errors++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        idle_inputs();
        rst = 1'b1;
        repeat (3) @(negedge clk);
        // R14: outputs cleared by reset
        check16("R14 reset ea_valid", {15'b0, ea_valid}, 16'h0);
        check16("R14 reset wb_en", {15'b0, wb_en}, 16'h0);
        check16("R14 reset ea", ea, 16'h0);
        rst = 1'b0;
        // R14: registers cleared (read W9 in register direct mode)
        drive_req(3'd1, 4'd9, 1'b0, 1'b0);
        @(negedge clk);
        check16("R14 reset reg value", reg_data, 16'h0000);
        idle_inputs();

        load_reg(4'd0, 16'h1000);
        load_reg(4'd1, 16'h2001);
        load_reg(4'd2, 16'h0010);
        load_reg(4'd3, 16'hFFFF);
        load_reg(4'd4, 16'h8000);
        load_reg(4'd5, 16'h0003);

        for (int i = 0; i < NVEC; i++) begin
            req_valid = 1'b1; mode = TBL[i].md; wn_sel = TBL[i].wn; wb_sel = TBL[i].wb;
            lit_ofs = TBL[i].lit; file_addr = TBL[i].fa; is_byte = TBL[i].byt;
            step_down = TBL[i].dn;
            @(negedge clk);
            check16($sformatf("R12 vec%0d ea_valid", i), {15'b0, ea_valid}, {15'b0, TBL[i].x_valid});
            check16($sformatf("R3 vec%0d ea", i), ea, TBL[i].x_ea);
            check16($sformatf("R2 vec%0d no_mem", i), {15'b0, no_mem}, {15'b0, TBL[i].x_nomem});
            check16($sformatf("R9 vec%0d addr_err", i), {15'b0, addr_err}, {15'b0, TBL[i].x_err});
            check16($sformatf("R4 vec%0d wb_en", i), {15'b0, wb_en}, {15'b0, TBL[i].x_wben});
            check16($sformatf("R5 vec%0d wb_data", i), wb_data, TBL[i].x_wbdata);
            check16($sformatf("R1 vec%0d reg_data", i), reg_data, TBL[i].x_reg);
            if (TBL[i].x_wben)
                check16($sformatf("R4 vec%0d wb_idx", i), {12'b0, wb_idx}, {12'b0, TBL[i].wn});
        end
        idle_inputs();
        @(negedge clk);
        // R12: no request leaves outputs quiet
        check16("R12 idle ea_valid", {15'b0, ea_valid}, 16'h0);
        check16("R12 idle wb_en", {15'b0, wb_en}, 16'h0);

        // R13: load visible on the next cycle
        load_reg(4'd7, 16'h5555);
        drive_req(3'd1, 4'd7, 1'b0, 1'b0);
        @(negedge clk);
        check16("R13 load visible", reg_data, 16'h5555);
        idle_inputs();

        // R13: load beats pending writeback to the same register
        load_reg(4'd6, 16'h0100);
        drive_req(3'd3, 4'd6, 1'b0, 1'b0);
        @(negedge clk);
        check16("R4 pending wb value", wb_data, 16'h0102);
        req_valid = 1'b0;
        ld_en = 1'b1; ld_idx = 4'd6; ld_data = 16'hABCD;
        @(negedge clk);
        idle_inputs();
        drive_req(3'd1, 4'd6, 1'b0, 1'b0);
        @(negedge clk);
        check16("R13 load wins", reg_data, 16'hABCD);
        idle_inputs();

        // R11 R3: writeback lands in the bank and persists after forwarding
        drive_req(3'd2, 4'd2, 1'b1, 1'b0);
        @(negedge clk);
        check16("R11 persisted pointer", ea, 16'h0011);
        idle_inputs();
        @(negedge clk);

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule